// File: doc/BRIEF.md
# Burst-Splitting Local Bus Read Controller with Burst Watchdog

This block sits between an internal master, typically a DMA engine, and a slow external target on a local bus. The master asks for a burst read of one to eight beats. If the target is marked as unable to take bursts, the controller serves the request as a run of single accesses. Each access raises chip select and output enable and holds them until the target returns its transfer acknowledge. Each completed access gives the master one beat acknowledge. Between two accesses, chip select is dropped for at least one cycle. If the target is marked burst-capable, the whole request is served as one access that ends with one acknowledge.

A watchdog times the whole burst, not each access. It starts when the request is accepted and is not restarted between the single accesses of that burst. A prescaler divides the clock by 2^`cfg_prescale` to make ticks. The limit is `cfg_limit` × 8 ticks, and a field value of 0 selects 256 × 8. When the limit is reached, the controller drops every control output without waiting for an acknowledge. It then returns a one-cycle transfer-error pulse in place of the beat acknowledge, and any remaining beats are dropped. Because the window covers the whole run, a series of slow acknowledges can abort a burst even when no single access is slow on its own.

Top module: `lbus_burst_split`

## Requirements
- R1: With `cfg_split`=1, a request whose `req_last` is N (beats = N+1) produces N+1 single accesses. Each access ends when `ext_ta` is sampled high, and each ends with exactly one one-cycle `m_ack` pulse in the cycle after that sample.
- R2: During an access, `ext_cs` and `ext_oe` are both high. They rise in the cycle after the request is accepted, or after a gap cycle, and stay high until `ext_ta` is sampled or the watchdog expires.
- R3: Consecutive single accesses of one burst are separated by at least one cycle with `ext_cs` low. After `ext_ta` is sampled with `ext_cs` high, `ext_cs` is low in the next cycle.
- R4: The watchdog counts from the acceptance edge and runs across all accesses and gaps of the burst. With P = 2^`cfg_prescale` and limit L ticks, the access acknowledged at edge e after acceptance completes only if e ≤ L·P. `m_err` appears at edge L·P+1 if the burst has not finished by then.
- R5: On expiry, `ext_cs` and `ext_oe` go low without an acknowledge, `m_err` pulses for one cycle, and no further `m_ack` or access follows for that burst. `m_ack` and `m_err` are never high together.
- R6: The limit is `cfg_limit` × 8 ticks. `cfg_limit`=0 means 256 × 8 = 2048 ticks.
- R7: One tick occurs every 2^`cfg_prescale` clock cycles while a burst is active.
- R8: Accepting a new request clears the watchdog. Back-to-back bursts, each close to the limit, all complete.
- R9: With `cfg_split`=0, the request is one access with a single `m_ack`, under the same watchdog.
- R10: `req_valid` is ignored while a burst is in progress. It starts no extra access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_split | input | 1 | 1: target cannot burst, split into single accesses |
| cfg_limit | input | 8 | Watchdog count field, limit = value × 8 ticks, 0 = 2048 |
| cfg_prescale | input | 4 | Tick prescaler exponent, tick every 2^value cycles |
| req_valid | input | 1 | Burst request, accepted when idle |
| req_last | input | 3 | Number of beats minus one |
| m_ack | output | 1 | One-cycle beat acknowledge to the master |
| m_err | output | 1 | One-cycle transfer-error pulse to the master |
| ext_cs | output | 1 | Chip select to the target, active high |
| ext_oe | output | 1 | Output enable to the target, active high |
| ext_ta | input | 1 | Transfer acknowledge from the target |

## Verification
The bench aims at the watchdog edges. In one test, an access is acknowledged exactly at the limit edge, so a design that is off by one would wrongly abort it. In another, the limit falls in the gap after an acknowledged beat, so a design that only checks the timer during an access would start one more access. Back-to-back bursts near the limit show whether the counter is cleared between bursts: a design that restarts the count per access never times out on a slow run, and one that never clears it fails the second burst. The tests also cover the prescaler, the field value 0 meaning 2048, and requests raised mid-burst, where a design that accepts them would produce extra accesses.

// File: rtl/lbsplit_pkg.sv
package lbsplit_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_GAP    = 2'd2
    } lbs_state_e;
endpackage

// File: rtl/lbsplit_prescale.sv
module lbsplit_prescale #(
    parameter int PS_W = 4,
    localparam int PRE_W = (1 << PS_W) - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            en,
    input  logic [PS_W-1:0] exp_sel,
    output logic            tick
);
    logic [PRE_W-1:0] pre_d, pre_q, mask;

    always_comb begin
        mask  = (PRE_W'(1) << exp_sel) - PRE_W'(1);
        tick  = en && ((pre_q & mask) == mask);
        pre_d = pre_q;
        if (clr)       pre_d = '0;
        else if (tick) pre_d = '0;
        else if (en)   pre_d = pre_q + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/lbsplit_monitor.sv
module lbsplit_monitor #(
    parameter int LIM_W = 8,
    localparam int CNT_W = LIM_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [LIM_W-1:0] limit_field,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q, limit;

    always_comb begin
        limit   = {1'b0, (limit_field == '0), limit_field, 3'b000};
        expired = (cnt_q == limit);
        cnt_d   = cnt_q;
        if (clr)                   cnt_d = '0;
        else if (tick && !expired) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lbus_burst_split.sv
module lbus_burst_split
    import lbsplit_pkg::*;
#(
    parameter int BEAT_W = 3,
    parameter int LIM_W  = 8,
    parameter int PS_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_split,
    input  logic [LIM_W-1:0]  cfg_limit,
    input  logic [PS_W-1:0]   cfg_prescale,
    input  logic              req_valid,
    input  logic [BEAT_W-1:0] req_last,
    output logic              m_ack,
    output logic              m_err,
    output logic              ext_cs,
    output logic              ext_oe,
    input  logic              ext_ta
);
    typedef struct packed {
        lbs_state_e        state;
        logic [BEAT_W-1:0] left;
        logic              split;
        logic              cs;
        logic              ack;
        logic              err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic accept, busy, tick, expired;

    assign accept = (ctl_q.state == ST_IDLE) && req_valid;
    assign busy   = (ctl_q.state != ST_IDLE);

    lbsplit_prescale #(.PS_W(PS_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(accept), .en(busy),
        .exp_sel(cfg_prescale), .tick(tick)
    );

    lbsplit_monitor #(.LIM_W(LIM_W)) u_mon (
        .clk(clk), .rst_n(rst_n), .clr(accept), .tick(tick),
        .limit_field(cfg_limit), .expired(expired)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.ack = 1'b0;
        ctl_d.err = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.state = ST_ACCESS;
                    ctl_d.left  = req_last;
                    ctl_d.split = cfg_split;
                    ctl_d.cs    = 1'b1;
                end
            end
            ST_ACCESS: begin
                if (expired) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.cs    = 1'b0;
                    ctl_d.err   = 1'b1;
                end else if (ext_ta) begin
                    ctl_d.ack = 1'b1;
                    ctl_d.cs  = 1'b0;
                    if (!ctl_q.split || ctl_q.left == '0) begin
                        ctl_d.state = ST_IDLE;
                    end else begin
                        ctl_d.state = ST_GAP;
                        ctl_d.left  = ctl_q.left - BEAT_W'(1);
                    end
                end
            end
            ST_GAP: begin
                if (expired) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.err   = 1'b1;
                end else begin
                    ctl_d.state = ST_ACCESS;
                    ctl_d.cs    = 1'b1;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
                ctl_d.cs    = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, left: '0, split: 1'b0,
                       cs: 1'b0, ack: 1'b0, err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign m_ack  = ctl_q.ack;
    assign m_err  = ctl_q.err;
    assign ext_cs = ctl_q.cs;
    assign ext_oe = ctl_q.cs;
endmodule

// File: rtl/lbsplit_chk.sv
module lbsplit_chk (
    input logic clk,
    input logic rst_n,
    input logic m_ack,
    input logic m_err,
    input logic ext_cs,
    input logic ext_oe,
    input logic ext_ta
);
    assert_ack_err_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({m_ack, m_err}));

    assert_ack_after_ta_R1: assert property (@(posedge clk) disable iff (!rst_n)
        m_ack |-> $past(ext_ta && ext_cs));

    assert_gap_after_ta_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_cs && ext_ta) |=> !ext_cs);

    assert_err_drops_ctl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        m_err |-> (!ext_cs && !ext_oe));

    assert_no_ack_after_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        m_err |=> !m_ack);

    assert_oe_with_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_cs) |-> ext_oe);
endmodule

bind lbus_burst_split lbsplit_chk chk_i (
    .clk(clk), .rst_n(rst_n), .m_ack(m_ack), .m_err(m_err),
    .ext_cs(ext_cs), .ext_oe(ext_oe), .ext_ta(ext_ta)
);

// File: tb/lbus_burst_split_tb.sv
module lbus_burst_split_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_split = 1'b1;
    logic [7:0] cfg_limit = 8'd4;
    logic [3:0] cfg_prescale = 4'd0;
    logic       req_valid = 1'b0;
    logic [2:0] req_last = 3'd0;
    logic       m_ack, m_err, ext_cs, ext_oe;
    logic       ext_ta = 1'b0;

    int vec_cnt = 0;
    int bad_cnt = 0;
    int cyc = 0;
    int lat [8];

    always #2 clk = ~clk;

    lbus_burst_split dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split), .cfg_limit(cfg_limit),
        .cfg_prescale(cfg_prescale), .req_valid(req_valid), .req_last(req_last),
        .m_ack(m_ack), .m_err(m_err), .ext_cs(ext_cs), .ext_oe(ext_oe),
        .ext_ta(ext_ta)
    );

    task automatic check(string tag, int act, int exp);
        vec_cnt++;
        if (act != exp) begin
            bad_cnt++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One burst: target answers beat i after lat[i] cycles of chip select.
    task automatic run_burst(string tag, bit split, int lim, int ps, int beats,
                             bit poke_req);
        int lp, e, exp_acks, exp_rises, acks, errs, err_n, rises, w, beat;
        bit prev_cs, all_low;
        lp = ((lim == 0) ? 2048 : lim * 8) * (1 << ps);
        // expected outcome from R4/R9
        exp_acks = 0; exp_rises = 1; e = 0;
        for (int i = 0; i < (split ? beats : 1); i++) begin
            e = (i == 0) ? lat[0] : e + 1 + lat[i];
            if (e <= lp) begin
                exp_acks++;
                if (i < (split ? beats : 1) - 1 && e < lp) exp_rises++;
            end else break;
        end
        cfg_split = split; cfg_limit = 8'(lim); cfg_prescale = 4'(ps);
        req_last = 3'(beats - 1);
        req_valid = 1'b1;
        acks = 0; errs = 0; err_n = 0; rises = 0; w = 0; beat = 0;
        prev_cs = 1'b0; all_low = 1'b1;
        for (int n = 1; n <= lp + 6; n++) begin
            @(negedge clk);
            req_valid = poke_req && (n == 3 || n == 4);
            if (m_ack) acks++;
            if (m_err) begin errs++; if (err_n == 0) err_n = n; end
            if (ext_cs && !prev_cs) rises++;
            if (ext_cs != ext_oe) all_low = 1'b0;
            prev_cs = ext_cs;
            if (ext_cs) begin
                w++;
                ext_ta = (beat < 8) && (w == lat[beat]);
                if (ext_ta) begin beat++; w = 0; end
            end else begin
                w = 0; ext_ta = 1'b0;
            end
        end
        req_valid = 1'b0; ext_ta = 1'b0;
        check({tag, " R1 beat acks"}, acks, exp_acks);
        check({tag, " R3 access count"}, rises, exp_rises);
        check({tag, " R5 error pulses"}, errs, (exp_acks < (split ? beats : 1)) ? 1 : 0);
        if (exp_acks < (split ? beats : 1))
            check({tag, " R4 error cycle"}, err_n, lp + 2);
        check({tag, " R2 oe tracks cs"}, int'(all_low), 1);
        check({tag, " R5 cs idle at end"}, int'(ext_cs), 0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R2 reset cs", int'(ext_cs), 0);
        check("R2 reset oe", int'(ext_oe), 0);
        check("R5 reset ack/err", int'({m_ack, m_err}), 0);
    endtask

    task automatic t_fast_split();
        for (int i = 0; i < 8; i++) lat[i] = 1;
        run_burst("R1 fast 8-beat", 1'b1, 4, 0, 8, 1'b0);
    endtask

    task automatic t_mixed_split();
        lat[0] = 3; lat[1] = 7; lat[2] = 2;
        run_burst("R1 mixed 3-beat", 1'b1, 4, 0, 3, 1'b0);
    endtask

    task automatic t_timeout_mid();
        for (int i = 0; i < 8; i++) lat[i] = 5;
        run_burst("R4 timeout mid-burst", 1'b1, 2, 0, 4, 1'b0);
    endtask

    task automatic t_timeout_gap();
        lat[0] = 5; lat[1] = 10; lat[2] = 1; lat[3] = 1;
        run_burst("R5 expiry in gap", 1'b1, 2, 0, 4, 1'b0);
    endtask

    task automatic t_prescale();
        for (int i = 0; i < 8; i++) lat[i] = 10;
        run_burst("R7 prescale x4", 1'b1, 1, 2, 5, 1'b0);
    endtask

    task automatic t_field_zero();
        for (int i = 0; i < 8; i++) lat[i] = 255;
        run_burst("R6 field0 pass", 1'b1, 0, 0, 8, 1'b0);
        for (int i = 0; i < 8; i++) lat[i] = 256;
        run_burst("R6 field0 abort", 1'b1, 0, 0, 8, 1'b0);
    endtask

    task automatic t_back_to_back();
        lat[0] = 8;
        run_burst("R8 first at limit", 1'b1, 1, 0, 1, 1'b0);
        run_burst("R8 second at limit", 1'b1, 1, 0, 1, 1'b0);
        lat[0] = 9;
        run_burst("R4 one past limit", 1'b1, 1, 0, 1, 1'b0);
    endtask

    task automatic t_no_split();
        for (int i = 0; i < 8; i++) lat[i] = 20;
        run_burst("R9 whole burst one access", 1'b0, 4, 0, 8, 1'b0);
        lat[0] = 40;
        run_burst("R9 whole burst timeout", 1'b0, 4, 0, 8, 1'b0);
    endtask

    task automatic t_req_busy();
        for (int i = 0; i < 8; i++) lat[i] = 2;
        run_burst("R10 request while busy", 1'b1, 4, 0, 3, 1'b1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad_cnt++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fast_split();
        t_mixed_split();
        t_timeout_mid();
        t_timeout_gap();
        t_prescale();
        t_field_zero();
        t_back_to_back();
        t_no_split();
        t_req_busy();
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end
endmodule